// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the hardware side of taking an exception in a 32-bit pipelined processor. The pipeline presents up to five fault requests in a cycle (instruction-side translation fault, instruction bus error, illegal opcode, data-side translation fault, data bus error) together with the program counter of the faulting instruction, whether that instruction sits in a branch delay slot, the branch target, two immediate-prefix indicators, a cause-specific status code and a faulting data address. The controller picks the oldest fault, and on the following clock edge it redirects fetch to the exception vector, flushes all younger instructions, writes a return address to the link register r17 and updates the machine status, exception status, exception address and branch target registers.

The saved return address depends on three facts: whether the faulting instruction is in a delay slot, whether the cause is a translation fault, and whether an immediate prefix came before it (or before its branch). On entry the user-mode and virtual-mode bits are moved into their save bits and cleared. A return-from-exception strobe restores them. With the fault-tolerant option, a bus or illegal-opcode fault that arrives while an exception is already being handled, or while exceptions are disabled, stops the pipeline for good and raises an error output. Without the option such a fault is simply not taken.

Top module: `exc_entry_ctrl`

## Requirements
- R1: One clock edge after a fault is accepted, `pc_load_o` and `flush_o` are high for exactly one cycle and `pc_new_o` equals BASE_VEC + 0x20.
- R2: For a fault outside a delay slot, r17 receives PC. For a translation fault whose instruction carries an immediate prefix, r17 receives PC-4 instead.
- R3: For a fault in a delay slot, esr bit [ESS_W+5] (delay-slot flag) is set and `btr_o` captures the branch target. A translation fault writes r17 with PC-8 if the branch had an immediate prefix and PC-4 if not. A bus or illegal-opcode fault in a delay slot leaves r17 unwritten (`r17_we_o` low).
- R4: Machine status bits are [0] enable, [1] in-progress, [2] user mode, [3] user save, [4] virtual mode, [5] virtual save. Entry clears [0], sets [1], copies [2] to [3] and [4] to [5], and clears [2] and [4].
- R5: The exception status register holds {delay-slot, cause[4:0], status[ESS_W-1:0]}. The cause codes are illegal opcode 1, instruction bus 3, data bus 4, data translation 16 and instruction translation 17. The status field takes `ess_i`. The address register takes PC for instruction-side causes and `fault_addr_i` for data-side ones.
- R6: When several requests arrive together, instruction translation wins over instruction bus, which wins over illegal opcode, then data translation, then data bus.
- R7: `resv_set_i` sets the reservation flag `resv_o`, and any exception entry clears it.
- R8: With FAULT_TOL=1, a bus or illegal-opcode fault while bit [1] is set or bit [0] is clear is not taken. Instead `halted_o` and `err_o` rise on the next edge.
- R9: Once halted, the block stays halted until reset. No further entry occurs and the status registers ignore writes, return strobes and faults.
- R10: With FAULT_TOL=0, a bus or illegal-opcode fault while bit [1] is set or bit [0] is clear is ignored with no register change. Translation faults are taken whatever the enable and in-progress bits are, in both variants.
- R11: `msr_wr_i` loads all six status bits from `msr_wdata_i`. `rte_i` sets [0], clears [1], and restores [2] from [3] and [4] from [5]. An exception entry takes precedence over both in the same cycle.
- R12: After reset all outputs and status registers are zero and the block is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_immu_i | input | 1 | Instruction-side translation fault |
| req_ibus_i | input | 1 | Instruction bus error |
| req_illop_i | input | 1 | Illegal opcode |
| req_dmmu_i | input | 1 | Data-side translation fault |
| req_dbus_i | input | 1 | Data bus error |
| pc_i | input | XLEN | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| br_target_i | input | XLEN | Target of the branch owning the delay slot |
| imm_pfx_i | input | 1 | Faulting instruction had an immediate prefix |
| br_imm_pfx_i | input | 1 | The branch had an immediate prefix |
| ess_i | input | ESS_W | Cause-specific status code |
| fault_addr_i | input | XLEN | Faulting data address |
| msr_wr_i | input | 1 | Write machine status bits |
| msr_wdata_i | input | 6 | Machine status write data |
| rte_i | input | 1 | Return from exception |
| resv_set_i | input | 1 | Load-reserve sets the reservation |
| pc_load_o | output | 1 | Redirect fetch to `pc_new_o` |
| pc_new_o | output | XLEN | Exception vector address |
| flush_o | output | 1 | Invalidate younger instructions |
| r17_we_o | output | 1 | Write return address to r17 |
| r17_o | output | XLEN | Return address |
| msr_o | output | 6 | Machine status bits |
| esr_o | output | ESS_W+6 | Exception status register |
| ear_o | output | XLEN | Exception address register |
| btr_o | output | XLEN | Branch target register |
| resv_o | output | 1 | Reservation flag |
| halted_o | output | 1 | Pipeline halted |
| err_o | output | 1 | External error indication |

## Verification
The hardest state to reach is a second fault arriving while the first is still being handled. The halt only appears when a bus or illegal-opcode fault lands with the in-progress bit set, and a nested translation fault has to be taken with the save bits holding the already-cleared mode bits. The bench takes a sequence of exceptions, leaves the last one unreturned, and sends a nested translation fault and then a nested bus fault. It drives a fault-tolerant and a non-fault-tolerant instance with the same stimulus, so the halt in one and the silent drop in the other are compared in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NCAUSE = 5;
   localparam int EC_W   = 5;
   localparam int MSR_W  = 6;

   localparam int MB_EE  = 0;
   localparam int MB_EIP = 1;
   localparam int MB_UM  = 2;
   localparam int MB_UMS = 3;
   localparam int MB_VM  = 4;
   localparam int MB_VMS = 5;

   typedef enum logic [2:0] {
      C_IMMU  = 3'd0,
      C_IBUS  = 3'd1,
      C_ILLOP = 3'd2,
      C_DMMU  = 3'd3,
      C_DBUS  = 3'd4
   } cause_e;

   function automatic logic [EC_W-1:0] ec_of(input cause_e c);
      case (c)
         C_IMMU:  return 5'd17;
         C_IBUS:  return 5'd3;
         C_ILLOP: return 5'd1;
         C_DMMU:  return 5'd16;
         default: return 5'd4;
      endcase
   endfunction

   function automatic logic is_xlat(input cause_e c);
      return (c == C_IMMU) || (c == C_DMMU);
   endfunction

   function automatic logic is_iside(input cause_e c);
      return (c == C_IMMU) || (c == C_IBUS) || (c == C_ILLOP);
   endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
   parameter int N = 5,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [SEL_W-1:0] sel
);
   always_comb begin
      any = |req;
      sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) sel = SEL_W'(i);
      end
   end
endmodule

// File: rtl/exc_gate.sv
module exc_gate
   import exc_pkg::*;
#(
   parameter bit FAULT_TOL = 1'b1
) (
   input  logic   any,
   input  cause_e cause,
   input  logic   ee,
   input  logic   eip,
   input  logic   halted,
   output logic   take,
   output logic   halt_req
);
   logic blocked;

   always_comb blocked = !is_xlat(cause) && (!ee || eip);

   generate
      if (FAULT_TOL) begin : g_ft
         always_comb begin
            take     = any && !blocked && !halted;
            halt_req = any &&  blocked && !halted;
         end
      end else begin : g_plain
         logic unused_h;
         always_comb begin
            take     = any && !blocked;
            halt_req = 1'b0;
            unused_h = halted;
         end
      end
   endgenerate
endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic            in_ds,
   input  logic            xlat,
   input  logic            imm_pfx,
   input  logic            br_imm_pfx,
   output logic [XLEN-1:0] ra,
   output logic            ra_we
);
   localparam logic [XLEN-1:0] STEP  = XLEN'(4);
   localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

   always_comb begin
      ra_we = 1'b1;
      ra    = pc;
      if (in_ds) begin
         if (xlat) begin
            ra = br_imm_pfx ? (pc - STEP2) : (pc - STEP);
         end else begin
            ra_we = 1'b0;
            ra    = pc - STEP;
         end
      end else if (xlat && imm_pfx) begin
         ra = pc - STEP;
      end
   end
endmodule

// File: rtl/exc_status.sv
module exc_status
   import exc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int ESS_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frozen,
   input  logic               take,
   input  cause_e             cause,
   input  logic               in_ds,
   input  logic [XLEN-1:0]    pc,
   input  logic [XLEN-1:0]    br_target,
   input  logic [XLEN-1:0]    fault_addr,
   input  logic [ESS_W-1:0]   ess,
   input  logic               msr_wr,
   input  logic [MSR_W-1:0]   msr_wdata,
   input  logic               rte,
   input  logic               resv_set,
   output logic [MSR_W-1:0]   msr,
   output logic [ESS_W+5:0]   esr,
   output logic [XLEN-1:0]    ear,
   output logic [XLEN-1:0]    btr,
   output logic               resv
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msr  <= '0;
         esr  <= '0;
         ear  <= '0;
         btr  <= '0;
         resv <= 1'b0;
      end else if (!frozen) begin
         if (take) begin
            msr[MB_EE]  <= 1'b0;
            msr[MB_EIP] <= 1'b1;
            msr[MB_UMS] <= msr[MB_UM];
            msr[MB_UM]  <= 1'b0;
            msr[MB_VMS] <= msr[MB_VM];
            msr[MB_VM]  <= 1'b0;
            esr         <= {in_ds, ec_of(cause), ess};
            ear         <= is_iside(cause) ? pc : fault_addr;
            if (in_ds) btr <= br_target;
            resv        <= 1'b0;
         end else begin
            if (rte) begin
               msr[MB_EE]  <= 1'b1;
               msr[MB_EIP] <= 1'b0;
               msr[MB_UM]  <= msr[MB_UMS];
               msr[MB_VM]  <= msr[MB_VMS];
            end else if (msr_wr) begin
               msr <= msr_wdata;
            end
            if (resv_set) resv <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              ESS_W     = 7,
   parameter logic [XLEN-1:0] BASE_VEC  = '0,
   parameter bit              FAULT_TOL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_immu_i,
   input  logic              req_ibus_i,
   input  logic              req_illop_i,
   input  logic              req_dmmu_i,
   input  logic              req_dbus_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              in_dslot_i,
   input  logic [XLEN-1:0]   br_target_i,
   input  logic              imm_pfx_i,
   input  logic              br_imm_pfx_i,
   input  logic [ESS_W-1:0]  ess_i,
   input  logic [XLEN-1:0]   fault_addr_i,
   input  logic              msr_wr_i,
   input  logic [5:0]        msr_wdata_i,
   input  logic              rte_i,
   input  logic              resv_set_i,
   output logic              pc_load_o,
   output logic [XLEN-1:0]   pc_new_o,
   output logic              flush_o,
   output logic              r17_we_o,
   output logic [XLEN-1:0]   r17_o,
   output logic [5:0]        msr_o,
   output logic [ESS_W+5:0]  esr_o,
   output logic [XLEN-1:0]   ear_o,
   output logic [XLEN-1:0]   btr_o,
   output logic              resv_o,
   output logic              halted_o,
   output logic              err_o
);
   localparam int              SEL_W  = $clog2(NCAUSE);
   localparam logic [XLEN-1:0] VECTOR = BASE_VEC + XLEN'(32'h20);

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("exc_entry_ctrl: XLEN must be at least 16");
      end
      if (ESS_W < 1 || ESS_W > 16) begin : g_bad_ess
         $error("exc_entry_ctrl: ESS_W out of range 1..16");
      end
      if (BASE_VEC[5:0] != 6'd0) begin : g_bad_base
         $error("exc_entry_ctrl: BASE_VEC must be 64-byte aligned");
      end
   endgenerate

   logic [NCAUSE-1:0] req_vec;
   logic              any_req;
   logic [SEL_W-1:0]  sel;
   cause_e            cause;
   logic              take;
   logic              halt_req;
   logic              halted;
   logic [XLEN-1:0]   ra;
   logic              ra_we;

   always_comb begin
      req_vec          = '0;
      req_vec[C_IMMU]  = req_immu_i;
      req_vec[C_IBUS]  = req_ibus_i;
      req_vec[C_ILLOP] = req_illop_i;
      req_vec[C_DMMU]  = req_dmmu_i;
      req_vec[C_DBUS]  = req_dbus_i;
      cause            = cause_e'(sel);
   end

   exc_prio #(.N(NCAUSE)) u_prio (
      .req (req_vec),
      .any (any_req),
      .sel (sel)
   );

   exc_gate #(.FAULT_TOL(FAULT_TOL)) u_gate (
      .any      (any_req),
      .cause    (cause),
      .ee       (msr_o[MB_EE]),
      .eip      (msr_o[MB_EIP]),
      .halted   (halted),
      .take     (take),
      .halt_req (halt_req)
   );

   exc_retaddr #(.XLEN(XLEN)) u_ra (
      .pc         (pc_i),
      .in_ds      (in_dslot_i),
      .xlat       (is_xlat(cause)),
      .imm_pfx    (imm_pfx_i),
      .br_imm_pfx (br_imm_pfx_i),
      .ra         (ra),
      .ra_we      (ra_we)
   );

   exc_status #(.XLEN(XLEN), .ESS_W(ESS_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .frozen     (halted),
      .take       (take),
      .cause      (cause),
      .in_ds      (in_dslot_i),
      .pc         (pc_i),
      .br_target  (br_target_i),
      .fault_addr (fault_addr_i),
      .ess        (ess_i),
      .msr_wr     (msr_wr_i),
      .msr_wdata  (msr_wdata_i),
      .rte        (rte_i),
      .resv_set   (resv_set_i),
      .msr        (msr_o),
      .esr        (esr_o),
      .ear        (ear_o),
      .btr        (btr_o),
      .resv       (resv_o)
   );

   generate
      if (FAULT_TOL) begin : g_halt
         logic halted_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) halted_q <= 1'b0;
            else if (halt_req) halted_q <= 1'b1;
         end
         assign halted = halted_q;
      end else begin : g_nohalt
         logic unused_hr;
         assign halted    = 1'b0;
         assign unused_hr = halt_req;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_load_o <= 1'b0;
         pc_new_o  <= '0;
         flush_o   <= 1'b0;
         r17_we_o  <= 1'b0;
         r17_o     <= '0;
      end else begin
         pc_load_o <= take;
         flush_o   <= take;
         r17_we_o  <= take && ra_we;
         if (take) begin
            pc_new_o <= VECTOR;
            r17_o    <= ra;
         end
      end
   end

   assign halted_o = halted;
   assign err_o    = halted;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int              XLEN     = 32,
   parameter int              ESS_W    = 7,
   parameter logic [XLEN-1:0] BASE_VEC = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [XLEN-1:0]   pc_i,
   input logic [XLEN-1:0]   br_target_i,
   input logic              pc_load_o,
   input logic [XLEN-1:0]   pc_new_o,
   input logic              flush_o,
   input logic              r17_we_o,
   input logic [XLEN-1:0]   r17_o,
   input logic [5:0]        msr_o,
   input logic [ESS_W+5:0]  esr_o,
   input logic [XLEN-1:0]   btr_o,
   input logic              resv_o,
   input logic              halted_o
);
   localparam int DS = ESS_W + 5;

   p_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (pc_new_o == BASE_VEC + XLEN'(32'h20) && flush_o));

   p_ret_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && r17_we_o && !esr_o[DS]) |->
      (r17_o == $past(pc_i) || r17_o == $past(pc_i) - XLEN'(4)));

   p_btr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && esr_o[DS]) |-> (btr_o == $past(br_target_i)));

   p_msr_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (!msr_o[0] && msr_o[1] && !msr_o[2] && !msr_o[4]));

   p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (msr_o[3] == $past(msr_o[2]) && msr_o[5] == $past(msr_o[4])));

   p_resv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> !resv_o);

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o);

   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> (!pc_load_o && $stable(msr_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .XLEN(XLEN), .ESS_W(ESS_W), .BASE_VEC(BASE_VEC)
) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
   localparam int          XLEN  = 32;
   localparam int          ESS_W = 7;
   localparam logic [31:0] BASE  = 32'h0001_0000;
   localparam logic [31:0] VEC   = BASE + 32'h20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic r_immu, r_ibus, r_illop, r_dmmu, r_dbus;
   logic [31:0] pc, brt, faddr;
   logic ds, ipfx, bpfx, mwr, rte, rset;
   logic [6:0] ess;
   logic [5:0] mwd;

   logic        pl, fl, we, rs, hl, er;
   logic [31:0] pn, ra, ear, btr;
   logic [5:0]  msr;
   logic [12:0] esr;
   logic        pl_n, fl_n, we_n, rs_n, hl_n, er_n;
   logic [31:0] pn_n, ra_n, ear_n, btr_n;
   logic [5:0]  msr_n;
   logic [12:0] esr_n;

   int checks = 0;
   int errors = 0;

   exc_entry_ctrl #(.XLEN(XLEN), .ESS_W(ESS_W), .BASE_VEC(BASE), .FAULT_TOL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_immu_i(r_immu), .req_ibus_i(r_ibus),
      .req_illop_i(r_illop), .req_dmmu_i(r_dmmu), .req_dbus_i(r_dbus), .pc_i(pc),
      .in_dslot_i(ds), .br_target_i(brt), .imm_pfx_i(ipfx), .br_imm_pfx_i(bpfx),
      .ess_i(ess), .fault_addr_i(faddr), .msr_wr_i(mwr), .msr_wdata_i(mwd),
      .rte_i(rte), .resv_set_i(rset), .pc_load_o(pl), .pc_new_o(pn), .flush_o(fl),
      .r17_we_o(we), .r17_o(ra), .msr_o(msr), .esr_o(esr), .ear_o(ear), .btr_o(btr),
      .resv_o(rs), .halted_o(hl), .err_o(er));

   exc_entry_ctrl #(.XLEN(XLEN), .ESS_W(ESS_W), .BASE_VEC(BASE), .FAULT_TOL(1'b0)) dut_plain (
      .clk(clk), .rst_n(rst_n), .req_immu_i(r_immu), .req_ibus_i(r_ibus),
      .req_illop_i(r_illop), .req_dmmu_i(r_dmmu), .req_dbus_i(r_dbus), .pc_i(pc),
      .in_dslot_i(ds), .br_target_i(brt), .imm_pfx_i(ipfx), .br_imm_pfx_i(bpfx),
      .ess_i(ess), .fault_addr_i(faddr), .msr_wr_i(mwr), .msr_wdata_i(mwd),
      .rte_i(rte), .resv_set_i(rset), .pc_load_o(pl_n), .pc_new_o(pn_n), .flush_o(fl_n),
      .r17_we_o(we_n), .r17_o(ra_n), .msr_o(msr_n), .esr_o(esr_n), .ear_o(ear_n),
      .btr_o(btr_n), .resv_o(rs_n), .halted_o(hl_n), .err_o(er_n));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      {r_immu, r_ibus, r_illop, r_dmmu, r_dbus} = '0;
      {ds, ipfx, bpfx, mwr, rte, rset} = '0;
      pc = '0; brt = '0; faddr = '0; ess = '0; mwd = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   function automatic logic [12:0] esr_exp(input logic d, input logic [4:0] ec, input logic [6:0] s);
      return {d, ec, s};
   endfunction

   task automatic do_rte();
      rte = 1'b1;
      step();
   endtask

   task automatic t_reset();
      chk("R12 pc_load", pl, 0);
      chk("R12 msr", msr, 0);
      chk("R12 esr", esr, 0);
      chk("R12 halted", hl, 0);
      chk("R12 resv", rs, 0);
      mwr = 1'b1; mwd = 6'b010101; rset = 1'b1;
      step();
      chk("R11 msr write", msr, 6'b010101);
      chk("R7 resv set", rs, 1);
      chk("R12 no entry", pl, 0);
   endtask

   task automatic t_ibus();
      pc = 32'h1000; ess = 7'h15; faddr = 32'hDEAD_0000; r_ibus = 1'b1;
      step();
      chk("R1 pc_load", pl, 1);
      chk("R1 flush", fl, 1);
      chk("R1 vector", pn, VEC);
      chk("R2 r17 we", we, 1);
      chk("R2 r17 = PC", ra, 32'h1000);
      chk("R4 msr entry", msr, 6'b101010);
      chk("R5 esr ibus", esr, esr_exp(0, 5'd3, 7'h15));
      chk("R5 ear iside", ear, 32'h1000);
      chk("R7 resv cleared", rs, 0);
      step();
      chk("R1 single pulse", pl, 0);
      chk("R1 flush single", fl, 0);
      do_rte();
      chk("R11 rte restore", msr, 6'b111101);
   endtask

   task automatic t_dmmu_ds_imm();
      pc = 32'h2000; brt = 32'h3000; faddr = 32'h4444; ess = 7'h2;
      ds = 1'b1; bpfx = 1'b1; r_dmmu = 1'b1;
      step();
      chk("R3 r17 PC-8", ra, 32'h1FF8);
      chk("R3 esr ds", esr, esr_exp(1, 5'd16, 7'h2));
      chk("R3 btr", btr, 32'h3000);
      chk("R5 ear dside", ear, 32'h4444);
      chk("R4 shadow", msr, 6'b101010);
      do_rte();
   endtask

   task automatic t_immu_imm();
      pc = 32'h5000; ipfx = 1'b1; r_immu = 1'b1; ess = 7'h7;
      step();
      chk("R2 r17 PC-4 imm", ra, 32'h4FFC);
      chk("R5 esr immu", esr, esr_exp(0, 5'd17, 7'h7));
      chk("R5 ear immu", ear, 32'h5000);
      do_rte();
   endtask

   task automatic t_dmmu_ds();
      pc = 32'h6000; brt = 32'h6100; ds = 1'b1; r_dmmu = 1'b1;
      step();
      chk("R3 r17 PC-4 ds", ra, 32'h5FFC);
      chk("R3 we ds mmu", we, 1);
      do_rte();
   endtask

   task automatic t_dbus_ds();
      pc = 32'h7000; brt = 32'h7100; faddr = 32'h9000; ds = 1'b1; r_dbus = 1'b1;
      step();
      chk("R3 entry", pl, 1);
      chk("R3 r17 not written", we, 0);
      chk("R3 btr dbus", btr, 32'h7100);
      chk("R5 esr dbus", esr, esr_exp(1, 5'd4, 7'h0));
      do_rte();
   endtask

   task automatic t_dmmu_plain();
      pc = 32'h8000; r_dmmu = 1'b1;
      step();
      chk("R2 r17 PC mmu", ra, 32'h8000);
      chk("R2 we", we, 1);
      do_rte();
   endtask

   task automatic t_priority();
      pc = 32'hA000; r_ibus = 1'b1; r_illop = 1'b1; r_dbus = 1'b1;
      step();
      chk("R6 ibus over illop", esr[11:7], 5'd3);
      do_rte();
      pc = 32'hA100; faddr = 32'hB000; r_illop = 1'b1; r_dmmu = 1'b1; r_dbus = 1'b1;
      step();
      chk("R6 illop over data", esr[11:7], 5'd1);
      chk("R6 ear illop", ear, 32'hA100);
      do_rte();
      pc = 32'hA200; r_immu = 1'b1; r_ibus = 1'b1;
      step();
      chk("R6 immu first", esr[11:7], 5'd17);
      rset = 1'b1; mwr = 1'b1; mwd = 6'b000001;
      r_dmmu = 1'b0;
      step();
      chk("R11 write", msr, 6'b000001);
      rset = 1'b1; mwr = 1'b1; mwd = 6'b010101; r_dmmu = 1'b1; pc = 32'hA300;
      step();
      chk("R11 entry over write", msr, 6'b000010);
      chk("R7 entry over set", rs, 0);
   endtask

   task automatic t_nested();
      pc = 32'hC000; faddr = 32'hC0C0; r_dmmu = 1'b1;
      step();
      chk("R10 nested xlat taken", pl, 1);
      chk("R10 nested xlat plain", pl_n, 1);
      chk("R10 no halt", hl, 0);
      pc = 32'hD000; r_ibus = 1'b1;
      step();
      chk("R8 halted", hl, 1);
      chk("R8 err", er, 1);
      chk("R8 no entry", pl, 0);
      chk("R10 plain ignored", pl_n, 0);
      chk("R10 plain msr kept", msr_n, 6'b000010);
      chk("R10 plain ear kept", ear_n, 32'hC0C0);
      chk("R10 plain not halted", hl_n, 0);
   endtask

   task automatic t_halted();
      mwr = 1'b1; mwd = 6'b010101; rset = 1'b1; r_dmmu = 1'b1; pc = 32'hE000;
      step();
      chk("R9 still halted", hl, 1);
      chk("R9 no entry", pl, 0);
      chk("R9 msr frozen", msr, 6'b000010);
      chk("R9 resv frozen", rs, 0);
      rte = 1'b1;
      step();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 rte ignored", msr, 6'b000010);
      chk("R9 err held", er, 1);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ibus();
      t_dmmu_ds_imm();
      t_immu_imm();
      t_dmmu_ds();
      t_dbus_ds();
      t_dmmu_plain();
      t_priority();
      t_nested();
      t_halted();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule